// File: doc/BRIEF.md
# ROM Single-Address-Fault Self-Diagnoser

This block takes over the read port of a column-multiplexed ROM and finds, for every column-select position, the one row that reads back wrong, if there is one. For each position it first loads two reference words from a pair of extra rows. It then reads every row of that position in ascending order. Each word is XOR-folded into a toggle register and also fed into a signature register, which steps once per word.

If the toggle register ends at zero, the position is clean and the block moves on. If it is nonzero, the toggle register holds the error pattern, and the signature register holds that pattern advanced by the number of steps that followed the bad row. The block then runs the signature register backward, using the reciprocal feedback, while a row counter walks down from the last row. The row at which the backward state equals the toggle residue is the faulty row. The ROM word read at that row, XORed with the residue, is the corrected word. The block sends the address and the corrected word to a repair buffer as a one-cycle write.

The ROM read port is treated as combinational: `rom_data` belongs to the `rom_addr` driven in the same cycle. Each ROM word has DATA_W data bits plus one modifier-column bit at the top.

Top module: `rom_fault_locator`

## Requirements
- R1: After reset, `rep_we`, `done`, `fault_found` and `diag_fail` are all 0.
- R2: Reference word layout. A reference word sits at an address with bit ADDR_W set to 1 and the column field equal to the position. Row field 0 holds the toggle reference and row field 1 holds the signature reference, each in the low DATA_W bits. The signature step is s' = {s[DATA_W-2:0],0} ^ (s[DATA_W-1] ? POLY : 0) ^ word, applied to rows 0 up to ROWS-1.
- R3: With fault-free contents and matching references, `done` rises BPC*(ROWS+3) cycles after the clock edge that samples `start`. No write occurs, and both flags stay 0.
- R4: Suppose exactly one row j at position p reads with an error in its data bits. Then exactly one write occurs for that position. `rep_addr` is {j,p}, with the row in the high bits and the column in the low bits. `rep_data` is the fault-free data word.
- R5: Positions are handled in ascending column order. Faults at different positions are each reported with their own single write, and `fault_found` is set.
- R6: Each faulty position located at row j adds ROWS-j cycles to the total run time.
- R7: The modifier bit (bit DATA_W of `rom_data`) has no effect on diagnosis.
- R8: Suppose the toggle residue is nonzero but no row matches during the walk down. Then `diag_fail` is set, that position writes nothing, and the position adds ROWS cycles.
- R9: A `start` pulse during a run is ignored. `done` stays high until the next `start`, and that next `start` clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a diagnosis run (taken when idle or done) |
| rom_addr | output | ADDR_W+1 | ROM address; the top bit selects the reference rows |
| rom_data | input | DATA_W+1 | ROM word for `rom_addr`, with the modifier bit on top |
| rep_we | output | 1 | One-cycle write strobe toward the repair buffer |
| rep_addr | output | ADDR_W | Faulty ROM address {row, column} |
| rep_data | output | DATA_W | Corrected data word |
| done | output | 1 | Run complete |
| fault_found | output | 1 | At least one repair written in this run |
| diag_fail | output | 1 | A nonzero residue had no matching row |

## Verification
The assertions assume that `rom_data` is a pure function of `rom_addr` within the cycle. They also assume that the ROM contents do not change while a run is in progress. Finally, they assume at most one faulty row per position, which keeps the backward walk unambiguous. The bench meets these assumptions as follows. It changes its behavioural array and reference rows only between runs, while `done` is high. It injects errors into one row per position only. It keeps ROWS well below the signature period of the default primitive polynomial.

// File: rtl/rom_diag_pkg.sv
package rom_diag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_TFF,
        ST_LD_SIG,
        ST_ACCUM,
        ST_CHECK,
        ST_BACK,
        ST_DONE
    } diag_state_e;

    localparam int REF_ROW_TFF = 0;
    localparam int REF_ROW_SIG = 1;
endpackage

// File: rtl/diag_sig_step.sv
module diag_sig_step #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] POLY = 'h1D
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] fwd,
    output logic [DATA_W-1:0] bwd
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] unfold;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        if (gi == 0) begin : g_lsb
            assign shifted[gi] = POLY[gi] & cur[DATA_W-1];
        end else begin : g_upper
            assign shifted[gi] = cur[gi-1] ^ (POLY[gi] & cur[DATA_W-1]);
        end
        assign unfold[gi] = cur[gi] ^ (POLY[gi] & cur[0]);
    end

    assign fwd = shifted ^ din;
    assign bwd = {cur[0], unfold[DATA_W-1:1]};
endmodule

// File: rtl/diag_addr_mux.sv
module diag_addr_mux #(
    parameter int ADDR_W = 6,
    parameter int COL_W  = 2
) (
    input  logic                    ref_sel,
    input  logic                    ref_idx,
    input  logic [ADDR_W-COL_W-1:0] row,
    input  logic [COL_W-1:0]        col,
    output logic [ADDR_W:0]         addr
);
    localparam int ROW_W = ADDR_W - COL_W;

    always_comb begin
        if (ref_sel) begin
            addr = {1'b1, ROW_W'(ref_idx), col};
        end else begin
            addr = {1'b0, row, col};
        end
    end
endmodule

// File: rtl/rom_fault_locator.sv
module rom_fault_locator
    import rom_diag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] POLY = 'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W:0]   rom_addr,
    input  logic [DATA_W:0]   rom_data,
    output logic              rep_we,
    output logic [ADDR_W-1:0] rep_addr,
    output logic [DATA_W-1:0] rep_data,
    output logic              done,
    output logic              fault_found,
    output logic              diag_fail
);
    localparam int ROW_W = ADDR_W - COL_W;

    typedef struct packed {
        diag_state_e       st;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] tff;
        logic [DATA_W-1:0] sig;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
        logic              found;
        logic              fail;
    } regs_t;

    regs_t q, d;

    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] sig_fwd;
    logic [DATA_W-1:0] sig_bwd;
    logic              adv;

    assign word = rom_data[DATA_W-1:0];

    diag_sig_step #(.DATA_W(DATA_W), .POLY(POLY)) u_sig (
        .cur (q.sig),
        .din (word),
        .fwd (sig_fwd),
        .bwd (sig_bwd)
    );

    diag_addr_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_mux (
        .ref_sel (q.st == ST_LD_TFF || q.st == ST_LD_SIG),
        .ref_idx (q.st == ST_LD_SIG),
        .row     (q.row),
        .col     (q.col),
        .addr    (rom_addr)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;
        adv  = 1'b0;
        case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    d.st    = ST_LD_TFF;
                    d.col   = '0;
                    d.found = 1'b0;
                    d.fail  = 1'b0;
                end
            end
            ST_LD_TFF: begin
                d.tff = word;
                d.st  = ST_LD_SIG;
            end
            ST_LD_SIG: begin
                d.sig = word;
                d.row = '0;
                d.st  = ST_ACCUM;
            end
            ST_ACCUM: begin
                d.tff = q.tff ^ word;
                d.sig = sig_fwd;
                if (&q.row) begin
                    d.st = ST_CHECK;
                end else begin
                    d.row = q.row + ROW_W'(1);
                end
            end
            ST_CHECK: begin
                if (q.tff == '0) begin
                    adv = 1'b1;
                end else begin
                    d.st = ST_BACK;
                end
            end
            ST_BACK: begin
                if (q.sig == q.tff) begin
                    d.we    = 1'b1;
                    d.waddr = {q.row, q.col};
                    d.wdata = word ^ q.tff;
                    d.found = 1'b1;
                    adv     = 1'b1;
                end else if (q.row == '0) begin
                    d.fail = 1'b1;
                    adv    = 1'b1;
                end else begin
                    d.sig = sig_bwd;
                    d.row = q.row - ROW_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (adv) begin
            if (&q.col) begin
                d.st = ST_DONE;
            end else begin
                d.col = q.col + COL_W'(1);
                d.st  = ST_LD_TFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rep_we      = q.we;
    assign rep_addr    = q.waddr;
    assign rep_data    = q.wdata;
    assign done        = (q.st == ST_DONE);
    assign fault_found = q.found;
    assign diag_fail   = q.fail;

    // Reference words are fetched from the extra rows only
    assert_ref_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LD_TFF || q.st == ST_LD_SIG) |-> rom_addr[ADDR_W]);

    // Backward walk moves down one row per clock
    assert_back_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BACK && $past(q.st) == ST_BACK) |-> (q.row == $past(q.row) - ROW_W'(1)));

    // Residue is frozen during the backward walk
    assert_tff_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BACK && $past(q.st) == ST_BACK) |-> $stable(q.tff));

    // Writes only follow a backward compare and last one cycle
    assert_write_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rep_we |-> ($past(q.st) == ST_BACK));
    assert_write_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rep_we |=> !rep_we);

    // Column advances by exactly one between positions
    assert_col_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LD_TFF && ($past(q.st) == ST_CHECK || $past(q.st) == ST_BACK))
            |-> (q.col == $past(q.col) + COL_W'(1)));

    // A failed walk never produces a write in the same step
    assert_fail_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_fail && !$past(diag_fail) && $past(q.st) == ST_BACK) |-> !rep_we);

    // Start during accumulation does not restart
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACCUM && start) |=> (q.st == ST_ACCUM || q.st == ST_CHECK));
endmodule

// File: tb/sim_rom_fault_locator.sv
module sim_rom_fault_locator;
    localparam int AW   = 6;
    localparam int CW   = 2;
    localparam int DW   = 8;
    localparam int ROWS = 1 << (AW - CW);
    localparam int BPC  = 1 << CW;
    localparam logic [DW-1:0] POLY = 8'h1D;
    localparam int BASE = BPC * (ROWS + 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW:0]   rom_addr;
    logic [DW:0]   rom_data;
    logic          rep_we;
    logic [AW-1:0] rep_addr;
    logic [DW-1:0] rep_data;
    logic done, fault_found, diag_fail;

    logic [DW:0]   mem [1 << AW];
    logic [DW-1:0] good [1 << AW];
    logic [DW-1:0] ref_tff [BPC];
    logic [DW-1:0] ref_sig [BPC];

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    logic [AW-1:0] wr_addr [8];
    logic [DW-1:0] wr_data [8];
    int cyc_total = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rom_fault_locator #(.ADDR_W(AW), .COL_W(CW), .DATA_W(DW), .POLY(POLY)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .rep_we(rep_we), .rep_addr(rep_addr), .rep_data(rep_data),
        .done(done), .fault_found(fault_found), .diag_fail(diag_fail)
    );

    always_comb begin
        if (rom_addr[AW]) begin
            rom_data = {1'b0, rom_addr[CW] ? ref_sig[rom_addr[CW-1:0]] : ref_tff[rom_addr[CW-1:0]]};
        end else begin
            rom_data = mem[rom_addr[AW-1:0]];
        end
    end

    always @(negedge clk) begin
        if (rep_we && wr_cnt < 8) begin
            wr_addr[wr_cnt] = rep_addr;
            wr_data[wr_cnt] = rep_data;
        end
        if (rep_we) wr_cnt = wr_cnt + 1;
    end

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000 && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc_total);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [DW-1:0] unstep(input logic [DW-1:0] t);
        logic [DW-1:0] u;
        u = t ^ (t[0] ? POLY : '0);
        return {t[0], u[DW-1:1]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // fill the array with fault-free contents and compute matching references (R2)
    task automatic prepare();
        for (int a = 0; a < (1 << AW); a++) begin
            good[a] = DW'((a * 53 + 29) ^ (a * a));
            mem[a]  = {1'(a % 2), good[a]};
        end
        for (int p = 0; p < BPC; p++) begin
            logic [DW-1:0] t, s;
            t = '0;
            s = '0;
            for (int r = ROWS - 1; r >= 0; r--) begin
                t = t ^ good[r * BPC + p];
                s = unstep(s ^ good[r * BPC + p]);
            end
            ref_tff[p] = t;
            ref_sig[p] = s;
        end
    endtask

    task automatic run(input bit glitch, output int cyc);
        wr_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        cyc = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            cyc = cyc + 1;
            if (glitch && cyc == 10) start = 1'b1;
            if (cyc > 5000) break;
        end
        #1;
    endtask

    initial begin
        int cyc;
        prepare();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rep_we == 1'b0, "R1 rep_we", int'(rep_we), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(fault_found == 1'b0 && diag_fail == 1'b0, "R1 flags",
            int'({fault_found, diag_fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 fault-free array
        run(1'b0, cyc);
        chk(cyc == BASE, "R3 latency", cyc, BASE);
        chk(wr_cnt == 0, "R2 R3 no write", wr_cnt, 0);
        chk(!fault_found && !diag_fail, "R3 flags", int'({fault_found, diag_fail}), 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R9 done held", int'(done), 1);

        // R4/R6 sweep: one faulty row at every position and row
        for (int p = 0; p < BPC; p++) begin
            for (int j = 0; j < ROWS; j++) begin
                logic [DW-1:0] e;
                int a;
                prepare();
                a = j * BPC + p;
                e = DW'(((p * ROWS + j) * 7) % 255 + 1);
                mem[a][DW-1:0] = mem[a][DW-1:0] ^ e;
                run(1'b0, cyc);
                chk(wr_cnt == 1, "R4 write count", wr_cnt, 1);
                chk(wr_addr[0] == AW'(a), "R4 rep_addr", int'(wr_addr[0]), a);
                chk(wr_data[0] == good[a], "R4 rep_data", int'(wr_data[0]), int'(good[a]));
                chk(cyc == BASE + ROWS - j, "R6 latency", cyc, BASE + ROWS - j);
                chk(fault_found && !diag_fail, "R4 flags", int'({fault_found, diag_fail}), 2);
            end
        end

        // R5 faults at three positions reported in column order
        prepare();
        mem[3 * BPC + 0][DW-1:0]  = mem[3 * BPC + 0][DW-1:0] ^ 8'h81;
        mem[15 * BPC + 2][DW-1:0] = mem[15 * BPC + 2][DW-1:0] ^ 8'h04;
        mem[0 * BPC + 3][DW-1:0]  = mem[0 * BPC + 3][DW-1:0] ^ 8'hFF;
        run(1'b0, cyc);
        chk(wr_cnt == 3, "R5 write count", wr_cnt, 3);
        chk(wr_addr[0] == AW'(12) && wr_data[0] == good[12], "R5 first", int'(wr_addr[0]), 12);
        chk(wr_addr[1] == AW'(62) && wr_data[1] == good[62], "R5 second", int'(wr_addr[1]), 62);
        chk(wr_addr[2] == AW'(3) && wr_data[2] == good[3], "R5 third", int'(wr_addr[2]), 3);
        chk(fault_found == 1'b1, "R5 fault_found", int'(fault_found), 1);
        chk(cyc == BASE + (ROWS - 3) + (ROWS - 15) + ROWS, "R6 multi latency",
            cyc, BASE + (ROWS - 3) + (ROWS - 15) + ROWS);

        // R7 modifier bit flipped only
        prepare();
        mem[3 * BPC + 1][DW] = ~mem[3 * BPC + 1][DW];
        mem[9 * BPC + 2][DW] = ~mem[9 * BPC + 2][DW];
        run(1'b0, cyc);
        chk(wr_cnt == 0, "R7 no write", wr_cnt, 0);
        chk(!fault_found && !diag_fail, "R7 flags", int'({fault_found, diag_fail}), 0);
        chk(cyc == BASE, "R7 latency", cyc, BASE);

        // R8 corrupt toggle reference: nonzero residue with no matching row
        prepare();
        ref_tff[2] = ref_tff[2] ^ 8'h5A;
        run(1'b0, cyc);
        chk(diag_fail == 1'b1, "R8 diag_fail", int'(diag_fail), 1);
        chk(wr_cnt == 0, "R8 no write", wr_cnt, 0);
        chk(fault_found == 1'b0, "R8 fault_found", int'(fault_found), 0);
        chk(cyc == BASE + ROWS, "R8 latency", cyc, BASE + ROWS);

        // R9 start during a run is ignored; next start clears flags
        prepare();
        mem[5 * BPC + 1][DW-1:0] = mem[5 * BPC + 1][DW-1:0] ^ 8'h10;
        run(1'b1, cyc);
        chk(cyc == BASE + ROWS - 5, "R9 latency with extra start", cyc, BASE + ROWS - 5);
        chk(wr_cnt == 1 && wr_addr[0] == AW'(21), "R9 single write", wr_cnt, 1);
        prepare();
        run(1'b0, cyc);
        chk(!fault_found && !diag_fail, "R9 flags cleared", int'({fault_found, diag_fail}), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule